// File: doc/BRIEF.md
# Up-Counting Timer with Buffered Prescale and Reload

The block is a free-running up-counter with two buffered settings: a clock prescaler and a reload limit. When the counter is enabled, the prescaler divides the clock by its active ratio. Each prescaler tick moves the counter up by one. When the counter reaches the active reload limit, the next tick returns it to zero. Software writes new prescale and reload values into holding (preload) registers at any time. Those values move into the active (shadow) copies only when an update event occurs. An update event is either a counter wrap or a software request.

Software reaches the block through a single-cycle write port. A 2-bit selector picks one of four slots: the control word, the prescale preload, the reload preload, or the flag-clear slot. The control word carries the enable bit, an update-suppress bit, a request-source bit and a self-clearing force-update strobe. The block has three outputs. The first is the live count. The second is a one-cycle update pulse. The third is a sticky update flag that software clears through the flag-clear slot.

Top module: `uptick_timer`

## Requirements
- R1: After reset the count, the update pulse and the update flag are all 0, the active and holding prescale and reload values are 0, and the counter stays at 0 until it is enabled.
- R2: The counter moves only while control bit 0 (enable) is 1. It advances once every P+1 clocks, where P is the active prescale value. When enable is cleared, the count holds.
- R3: With active reload value A, the count runs 0, 1, …, A and then returns to 0. At that wrap the update pulse is high for the one cycle in which the count shows 0, and the update flag is set.
- R4: Writing selector 1 (prescale) or selector 2 (reload) changes only the holding registers. The active values change only at an update event, and the next period uses them.
- R5: Writing selector 0 with bit 3 (force-update) set clears both the counter and the prescaler phase at that write. When bit 1 of the same write is 0, the write also produces an update event: the update pulse is high in the following cycle and both active values are loaded.
- R6: While control bit 1 (update-suppress) is 1, a wrap still returns the count to 0 but raises no pulse, sets no flag and leaves the active values unchanged. A force-update in that state still restarts the counter, but it raises no pulse.
- R7: A force-update written with control bit 2 (request-source) at 1 raises the pulse but does not set the flag. The same force-update with bit 2 at 0 sets the flag. A counter wrap sets the flag whatever bit 2 holds.
- R8: The flag stays set until a write to selector 3 with data bit 0 at 1 clears it. A selector-3 write with bit 0 at 0 has no effect. A set and a clear in the same cycle leave the flag set.
- R9: The force-update bit does not stay set: one write produces exactly one update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | Slot: 0 control, 1 prescale, 2 reload, 3 flag clear |
| wr_data | input | DATA_W (16) | Write data |
| count | output | CNT_W (16) | Current count |
| update_pulse | output | 1 | One-cycle pulse after each update event |
| update_flag | output | 1 | Sticky update flag |

## Verification
Every result is due on the clock edge that follows its cause, and is visible from that edge onward. A write is captured at its edge, so the count, pulse and flag that come from a force-update or a clear can be read right after that edge. An enable takes effect one edge after it is written. With prescale P, the count after k further edges is floor(k/(P+1)) modulo A+1. Each wrap, and the pulse and flag that go with it, falls on the edge where that value would reach A+1. The bench drives inputs on the falling edge and reads outputs on the next falling edge. It counts edges from each write and checks the values just before and just after every wrap.

// File: rtl/tmr_pkg.sv
// Package: shared types and field positions of the timer's write port.
// Assumes the control word fits in the low four bits of the write data.
package tmr_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_PSC  = 2'd1,
        SEL_ARR  = 2'd2,
        SEL_CLR  = 2'd3
    } tmr_sel_e;

    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_UDIS = 1;
    localparam int unsigned BIT_URS  = 2;
    localparam int unsigned BIT_UG   = 3;
    localparam int unsigned BIT_CLR  = 0;

    typedef struct packed {
        logic urs;
        logic udis;
        logic en;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_regs.sv
// Module: write decode for the control word and the two preload registers.
// It also decodes the force-update strobe and the flag-clear strobe, both as
// single-cycle combinational pulses. A force-update carries the control values
// written with it. Assumes DATA_W >= PSC_W, DATA_W >= CNT_W and DATA_W >= 4.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned PSC_W  = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output tmr_ctrl_t         ctrl_q,
    output logic [PSC_W-1:0]  psc_pre_q,
    output logic [CNT_W-1:0]  arr_pre_q,
    output logic              ug_req,
    output tmr_ctrl_t         ug_ctrl,
    output logic              clr_req
);

    tmr_sel_e  sel;
    logic      ctrl_wr;
    tmr_ctrl_t ctrl_new;

    // Decode the slot being written and the control value it carries.
    always_comb begin
        sel           = tmr_sel_e'(wr_sel);
        ctrl_wr       = wr_en && (sel == SEL_CTRL);
        ctrl_new.en   = wr_data[BIT_EN];
        ctrl_new.udis = wr_data[BIT_UDIS];
        ctrl_new.urs  = wr_data[BIT_URS];
        ug_req        = ctrl_wr && wr_data[BIT_UG];
        ug_ctrl       = ctrl_new;
        clr_req       = wr_en && (sel == SEL_CLR) && wr_data[BIT_CLR];
    end

    // Hold the control bits and the two preload values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            psc_pre_q <= '0;
            arr_pre_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= ctrl_new;
            end
            if (wr_en && (sel == SEL_PSC)) begin
                psc_pre_q <= wr_data[PSC_W-1:0];
            end
            if (wr_en && (sel == SEL_ARR)) begin
                arr_pre_q <= wr_data[CNT_W-1:0];
            end
        end
    end

    p_ctrl_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl_q));

endmodule

// File: rtl/tmr_prescaler.sv
// Module: clock prescaler with a shadowed ratio.
// A phase counter runs from 0 up to the active value. It gives one tick as it
// wraps, so the ratio is value+1. A restart clears the phase. A load copies
// the preload into the active ratio. Assumes load and restart are pulses.
module tmr_prescaler #(
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic             load,
    input  logic [PSC_W-1:0] psc_pre,
    output logic             tick
);

    logic [PSC_W-1:0] psc_act_q;
    logic [PSC_W-1:0] phase_q;

    // Tick when enabled and the phase reaches the active ratio.
    always_comb begin
        tick = en && (phase_q == psc_act_q);
    end

    // Advance or restart the phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || tick) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Reload the active ratio on an update event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_act_q <= '0;
        end else if (load) begin
            psc_act_q <= psc_pre;
        end
    end

    p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= psc_act_q);

    p_ratio_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(psc_act_q));

endmodule

// File: rtl/tmr_counter.sv
// Module: up-counter with a shadowed reload limit.
// On each tick it counts up to the active limit and then wraps to 0. The
// overflow output flags that wrap tick. A restart clears the count. A load
// copies the preload into the active limit. Assumes tick is already gated by
// the enable.
module tmr_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             load,
    input  logic [CNT_W-1:0] arr_pre,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf
);

    logic [CNT_W-1:0] arr_act_q;

    // Overflow is the tick that finds the count at the active limit.
    always_comb begin
        ovf = tick && (cnt_q == arr_act_q);
    end

    // Count up, wrap at the limit, or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || ovf) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Reload the active limit on an update event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_act_q <= '0;
        end else if (load) begin
            arr_act_q <= arr_pre;
        end
    end

    p_within_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= arr_act_q);

    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt_q));

    p_limit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(arr_act_q));

endmodule

// File: rtl/tmr_flag.sv
// Module: update pulse register and sticky update flag.
// The pulse is high for the cycle after each update event. The flag is set by
// a set request and cleared by a clear request. A set wins over a clear in
// the same cycle.
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic uev,
    input  logic set_req,
    input  logic clr_req,
    output logic pulse_q,
    output logic flag_q
);

    // Register the update event as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= uev;
        end
    end

    // Keep the flag set until cleared; a set in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_req) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> flag_q);

endmodule

// File: rtl/uptick_timer.sv
// Module: top level of the up-counting timer with buffered prescale and reload.
// It joins write decode, prescaler, counter and flag logic, and forms the
// update event. A force-update takes priority over a wrap in the same cycle.
// Assumes one write per cycle on the write port.
module uptick_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PSC_W = 16,
    localparam int unsigned DATA_W = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              update_pulse,
    output logic              update_flag
);

    tmr_ctrl_t        ctrl_q;
    tmr_ctrl_t        ug_ctrl;
    logic [PSC_W-1:0] psc_pre_q;
    logic [CNT_W-1:0] arr_pre_q;
    logic             ug_req;
    logic             clr_req;
    logic             tick;
    logic             ovf;
    logic             uev;
    logic             flag_set;

    tmr_regs #(
        .PSC_W  (PSC_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ctrl_q    (ctrl_q),
        .psc_pre_q (psc_pre_q),
        .arr_pre_q (arr_pre_q),
        .ug_req    (ug_req),
        .ug_ctrl   (ug_ctrl),
        .clr_req   (clr_req)
    );

    // Form the update event and the flag set from a force-update or a wrap.
    always_comb begin
        if (ug_req) begin
            uev      = !ug_ctrl.udis;
            flag_set = !ug_ctrl.udis && !ug_ctrl.urs;
        end else begin
            uev      = ovf && !ctrl_q.udis;
            flag_set = ovf && !ctrl_q.udis;
        end
    end

    tmr_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl_q.en),
        .restart (ug_req),
        .load    (uev),
        .psc_pre (psc_pre_q),
        .tick    (tick)
    );

    tmr_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (ug_req),
        .load    (uev),
        .arr_pre (arr_pre_q),
        .cnt_q   (count),
        .ovf     (ovf)
    );

    tmr_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .uev     (uev),
        .set_req (flag_set),
        .clr_req (clr_req),
        .pulse_q (update_pulse),
        .flag_q  (update_flag)
    );

    p_ug_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ug_req |=> (count == '0));

    p_ug_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ug_req && !ug_ctrl.udis) |=> update_pulse);

    p_udis_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && ctrl_q.udis && !ug_req) |=> !update_pulse);

    p_urs_noflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ug_req && ug_ctrl.urs && !update_flag && !ovf) |=> !update_flag);

endmodule

// File: tb/uptick_timer_tb.sv
// Directed bench for uptick_timer: one task per scenario. Inputs change on
// the falling edge and outputs are read on the falling edge.
module uptick_timer_tb;

    localparam int unsigned W = 16;
    localparam logic [W-1:0] C_EN   = 16'h0001;
    localparam logic [W-1:0] C_UDIS = 16'h0002;
    localparam logic [W-1:0] C_URS  = 16'h0004;
    localparam logic [W-1:0] C_UG   = 16'h0008;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count;
    logic         update_pulse;
    logic         update_flag;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    uptick_timer #(.CNT_W(W), .PSC_W(W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .count        (count),
        .update_pulse (update_pulse),
        .update_flag  (update_flag)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input int c, input int p, input int f);
        check(req, "count", int'(count), c);
        check(req, "pulse", int'(update_pulse), p);
        check(req, "flag", int'(update_flag), f);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [W-1:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic setup(input logic [W-1:0] psc, input logic [W-1:0] arr);
        wr(2'd0, '0);
        wr(2'd1, psc);
        wr(2'd2, arr);
        wr(2'd0, C_UG);
        wr(2'd3, 16'h0001);
    endtask

    task automatic t_reset();
        expect_out("R1", 0, 0, 0);
        idle(5);
        expect_out("R1", 0, 0, 0);
    endtask

    task automatic t_wrap();
        setup(16'd0, 16'h0036);
        wr(2'd0, C_EN);
        idle(16'h36);
        expect_out("R3", 16'h36, 0, 0);
        idle(1);
        expect_out("R3", 0, 1, 1);
        idle(1);
        expect_out("R3", 1, 0, 1);
    endtask

    task automatic t_presc();
        setup(16'd2, 16'd100);
        wr(2'd0, C_EN);
        idle(5);
        check("R2", "count div3 k5", int'(count), 1);
        idle(1);
        check("R2", "count div3 k6", int'(count), 2);
        wr(2'd0, '0);
        idle(10);
        check("R2", "count held while disabled", int'(count), 2);
    endtask

    task automatic t_preload();
        setup(16'd0, 16'd5);
        wr(2'd2, 16'd3);
        wr(2'd1, 16'd1);
        check("R4", "count after preload writes", int'(count), 0);
        wr(2'd0, C_EN);
        idle(5);
        expect_out("R4", 5, 0, 0);
        idle(1);
        expect_out("R4", 0, 1, 1);
        idle(2);
        check("R4", "new ratio count", int'(count), 1);
        idle(5);
        expect_out("R4", 3, 0, 1);
        idle(1);
        expect_out("R4", 0, 1, 1);
    endtask

    task automatic t_ug();
        setup(16'd3, 16'd50);
        wr(2'd0, C_EN);
        idle(6);
        check("R5", "count before force", int'(count), 1);
        wr(2'd0, C_EN | C_UG);
        expect_out("R5", 0, 1, 1);
        idle(1);
        check("R9", "pulse drops after one cycle", int'(update_pulse), 0);
        idle(2);
        check("R5", "prescaler restarted k3", int'(count), 0);
        idle(1);
        check("R5", "prescaler restarted k4", int'(count), 1);
    endtask

    task automatic t_udis();
        setup(16'd0, 16'd3);
        wr(2'd2, 16'd1);
        wr(2'd0, C_EN | C_UDIS);
        idle(3);
        expect_out("R6", 3, 0, 0);
        idle(1);
        expect_out("R6", 0, 0, 0);
        idle(3);
        check("R6", "limit kept", int'(count), 3);
        wr(2'd0, C_EN | C_UDIS | C_UG);
        expect_out("R6", 0, 0, 0);
        idle(3);
        check("R6", "limit kept after force", int'(count), 3);
    endtask

    task automatic t_urs();
        setup(16'd0, 16'd4);
        wr(2'd2, 16'd2);
        wr(2'd0, C_URS | C_UG);
        expect_out("R7", 0, 1, 0);
        wr(2'd0, C_EN | C_URS);
        idle(2);
        expect_out("R7", 2, 0, 0);
        idle(1);
        expect_out("R7", 0, 1, 1);
    endtask

    task automatic t_flag();
        setup(16'd0, 16'd3);
        wr(2'd0, C_EN);
        idle(3);
        wr(2'd3, 16'h0001);
        expect_out("R8", 0, 1, 1);
        wr(2'd0, '0);
        idle(5);
        check("R8", "flag sticky", int'(update_flag), 1);
        wr(2'd3, 16'h0000);
        check("R8", "clear with bit0=0 ignored", int'(update_flag), 1);
        wr(2'd3, 16'h0001);
        check("R8", "flag cleared", int'(update_flag), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_wrap();
        t_presc();
        t_preload();
        t_ug();
        t_udis();
        t_urs();
        t_flag();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule